// File: doc/BRIEF.md
# Clock Generator Watchdog Supervisor

This block supervises a programmable clock synthesizer. Once software arms it, it counts down a timeout measured in coarse base periods. Each base period is a fixed number of pulses on a timebase tick input. Software keeps the system alive either by pulsing a refresh strobe or by rewriting the control register. If neither happens before the count runs out, the block raises an alarm.

There are two alarm flavours. A hard alarm drives an active-low system reset pulse. It also replaces the active 5-bit frequency-select code with a fallback: either a programmed safe code or the strap code captured during reset. A soft alarm only raises a status flag. Separately, the reset pulse can be requested whenever software moves the frequency-select code to a new value (a gear change).

All state sits behind a small register port with four byte-wide locations: frequency code, control, safe code and status. Reads are combinational on the address.

Top module: `clkwd_supervisor`

## Requirements
- R1: After reset, `sys_rst_n` is 1, `freq_sel` equals the strap code present during reset, control (address 1) reads 0x07 and status (address 3) reads 0x00.
- R2: While the enable bit (control bit 4) is 0, ticks never raise an alarm, and both status bits (address 3 bit 0 = hard, bit 1 = soft) read 0.
- R3: Arming loads a countdown of X·B ticks. X is control bits 2:0. B is SHORT_TICKS when control bit 3 is 0 and LONG_TICKS when it is 1. The alarm sets on the X·B-th tick after the load, and not before.
- R4: A refresh pulse or any write to the control register reloads the full countdown.
- R5: A hard expiry (control bit 5 = 0) sets status bit 0 and drives `sys_rst_n` low from the next cycle. The pulse lasts until PULSE_TICKS further ticks have occurred. When control bit 7 is 1, `freq_sel` takes the safe code (address 2, bits 4:0).
- R6: A hard expiry with control bit 7 = 0 restores `freq_sel` to the strap code latched at reset.
- R7: With control bit 5 = 1, expiry sets only status bit 1. `sys_rst_n` stays 1 and `freq_sel` is unchanged.
- R8: An alarm stays set, and no new expiry occurs, until the enable bit is cleared. Clearing the enable bit clears both status bits.
- R9: When gear reset (control bit 6) is 1, a write to address 0 that changes the code starts a reset pulse. A write of the same code starts none, and neither does any write while bit 6 is 0.
- R10: `freq_sel` changes only on a write to address 0 (bits 4:0) or on a hard expiry.
- R11: X = 0 expires on the first tick after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse |
| refresh | input | 1 | One-cycle watchdog refresh strobe |
| strap_code | input | 5 | Strap frequency code, captured while in reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 freq, 1 control, 2 safe, 3 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| freq_sel | output | 5 | Active frequency-select code |

## Verification
The assertions assume that `tick`, `refresh` and `reg_wr` are single-cycle strobes sampled on the rising clock edge. They also assume that `strap_code` is stable around the release of reset. The stimulus therefore drives every input on the falling edge and holds each strobe for exactly one cycle. It never writes the status location. It waits out each reset pulse before starting the next scenario, so every pulse length can be observed in isolation.

// File: rtl/clkwd_supervisor.sv
module clkwd_supervisor #(
  parameter int SHORT_TICKS = 290,
  parameter int LONG_TICKS  = 1160,
  parameter int PULSE_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       refresh,
  input  logic [4:0] strap_code,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sys_rst_n,
  output logic [4:0] freq_sel
);
  localparam int CW = $clog2(7 * LONG_TICKS + 1);
  localparam int PW = $clog2(PULSE_TICKS + 1);

  logic [7:0]    ctrl_q;
  logic [4:0]    safe_q, strap_q, freq_q;
  logic          hard_q, soft_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pcnt_q;

  wire wr_freq = reg_wr && reg_addr == 2'd0;
  wire wr_ctrl = reg_wr && reg_addr == 2'd1;
  wire wr_safe = reg_wr && reg_addr == 2'd2;

  wire [7:0] ctrl_nx = wr_ctrl ? reg_wdata : ctrl_q;
  wire [CW-1:0] load_val =
    CW'(int'(ctrl_nx[2:0]) * (ctrl_nx[3] ? LONG_TICKS : SHORT_TICKS));

  wire en        = ctrl_q[4];
  wire expire    = en && !hard_q && !soft_q && tick && !refresh && !wr_ctrl
                   && cnt_q <= CW'(1);
  wire hard_fire = expire && !ctrl_q[5];
  wire soft_fire = expire && ctrl_q[5];
  wire gear_fire = wr_freq && ctrl_q[6] && reg_wdata[4:0] != freq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= 8'h07;
      safe_q  <= '0;
      strap_q <= strap_code;
    end else begin
      ctrl_q <= ctrl_nx;
      if (wr_safe) safe_q <= reg_wdata[4:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (!en || refresh || wr_ctrl) cnt_q <= load_val;
    else if (tick && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hard_q <= 1'b0;
      soft_q <= 1'b0;
    end else if (!en) begin
      hard_q <= 1'b0;
      soft_q <= 1'b0;
    end else begin
      if (hard_fire) hard_q <= 1'b1;
      if (soft_fire) soft_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pcnt_q <= '0;
    else if (hard_fire || gear_fire) pcnt_q <= PW'(PULSE_TICKS);
    else if (tick && pcnt_q != '0)   pcnt_q <= pcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         freq_q <= strap_code;
    else if (hard_fire) freq_q <= ctrl_q[7] ? safe_q : strap_q;
    else if (wr_freq)   freq_q <= reg_wdata[4:0];
  end

  assign sys_rst_n = (pcnt_q == '0);
  assign freq_sel  = freq_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {3'b000, freq_q};
      2'd1:    reg_rdata = ctrl_q;
      2'd2:    reg_rdata = {3'b000, safe_q};
      default: reg_rdata = {6'b0, soft_q, hard_q};
    endcase
  end

  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hard_q && !soft_q));
  assert_hard_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hard_fire |=> !sys_rst_n);
  assert_soft_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_fire |=> (soft_q && !hard_q));
  assert_one_alarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hard_q, soft_q}));
  assert_alarm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hard_q && en && !wr_ctrl) |=> hard_q);
  assert_gear_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gear_fire |=> !sys_rst_n);
  assert_freq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_freq && !hard_fire) |=> $stable(freq_sel));
endmodule

// File: tb/clkwd_supervisor_test.sv
module clkwd_supervisor_test;
  logic clk = 0, rst_n = 0, tick = 0, refresh = 0, reg_wr = 0;
  logic [4:0] strap_code = 5'h0B;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic sys_rst_n;
  logic [4:0] freq_sel;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clkwd_supervisor #(.SHORT_TICKS(3), .LONG_TICKS(12), .PULSE_TICKS(16)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .refresh(refresh),
    .strap_code(strap_code), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst_n(sys_rst_n),
    .freq_sel(freq_sel));

  typedef struct {int kind; logic [1:0] a; logic [7:0] v; string tag;} item_t;
  item_t q[$];

  // kind 0: register read at a, 1: freq_sel, 2: sys_rst_n
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it = q.pop_front();
      reg_addr = it.a;
      #1;
      got = it.kind == 0 ? reg_rdata :
            it.kind == 1 ? {3'b000, freq_sel} : {7'b0, sys_rst_n};
      checks++;
      if (got !== it.v) begin
        failures++;
        $display("FAIL %s got=%h exp=%h", it.tag, got, it.v);
      end
    end
  end

  task automatic expect_item(input int kind, input logic [1:0] a,
                             input logic [7:0] v, input string tag);
    item_t it;
    it.kind = kind; it.a = a; it.v = v; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic pulse_refresh();
    @(negedge clk); refresh = 1;
    @(negedge clk); refresh = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    strap_code = 5'h1F;
    expect_item(2, 0, 8'h01, "R1 rst_n");
    expect_item(1, 0, 8'h0B, "R1 freq strap");
    expect_item(0, 1, 8'h07, "R1 ctrl default");
    expect_item(0, 3, 8'h00, "R1 status");

    ticks(30);
    expect_item(0, 3, 8'h00, "R2 disabled status");
    expect_item(2, 0, 8'h01, "R2 disabled rst_n");

    wr(0, 8'h03);
    expect_item(1, 0, 8'h03, "R10 freq write");
    expect_item(2, 0, 8'h01, "R9 no gear pulse when bit6=0");
    wr(1, 8'h12);
    ticks(5);
    expect_item(0, 3, 8'h00, "R3 not before X*B");
    ticks(1);
    expect_item(0, 3, 8'h01, "R3 hard alarm at X*B");
    expect_item(2, 0, 8'h00, "R5 reset asserted");
    expect_item(1, 0, 8'h0B, "R6 strap restored");
    ticks(15);
    expect_item(2, 0, 8'h00, "R5 pulse still low at 15");
    ticks(1);
    expect_item(2, 0, 8'h01, "R5 pulse ends at 16");
    pulse_refresh();
    ticks(20);
    expect_item(0, 3, 8'h01, "R8 alarm sticky");
    expect_item(2, 0, 8'h01, "R8 no re-expiry");
    expect_item(1, 0, 8'h0B, "R10 freq held");

    wr(1, 8'h02);
    expect_item(0, 3, 8'h00, "R8 cleared by disable");
    wr(2, 8'h15);
    wr(1, 8'h99);
    ticks(10);
    pulse_refresh();
    ticks(11);
    expect_item(0, 3, 8'h00, "R4 refresh restarts");
    ticks(1);
    expect_item(0, 3, 8'h01, "R5 expiry after refresh");
    expect_item(1, 0, 8'h15, "R5 safe code applied");
    ticks(16);

    wr(1, 8'h00);
    wr(1, 8'h11);
    ticks(2);
    wr(1, 8'h11);
    ticks(2);
    expect_item(0, 3, 8'h00, "R4 ctrl write restarts");
    ticks(1);
    expect_item(0, 3, 8'h01, "R4 expiry after ctrl reload");
    expect_item(1, 0, 8'h0B, "R6 strap code on expiry");
    ticks(16);

    wr(1, 8'h00);
    wr(1, 8'h31);
    ticks(3);
    expect_item(0, 3, 8'h02, "R7 soft alarm only");
    expect_item(2, 0, 8'h01, "R7 no reset");
    expect_item(1, 0, 8'h0B, "R7 freq unchanged");

    wr(1, 8'h40);
    expect_item(0, 3, 8'h00, "R2 soft cleared when disabled");
    wr(0, 8'h07);
    expect_item(2, 0, 8'h00, "R9 gear change pulse");
    ticks(16);
    expect_item(2, 0, 8'h01, "R9 gear pulse ends");
    wr(0, 8'h07);
    expect_item(2, 0, 8'h01, "R9 same code no pulse");

    wr(1, 8'h10);
    ticks(1);
    expect_item(0, 3, 8'h01, "R11 X=0 expires on first tick");
    expect_item(1, 0, 8'h0B, "R11 strap applied");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule